// File: doc/BRIEF.md
# Delay-Slot Legality Checker

This block sits beside the decode stage and watches the stream of decoded instructions. Every valid instruction arrives with a set of class flags produced elsewhere. When a delayed branch is decoded, the checker opens a one-instruction window, the delay slot, and keeps the branch target. The next valid instruction is judged against the rules for the slot. If it is not allowed there, the checker raises a slot-illegal request for the exception sequencer. The request carries the stored branch target as the PC to be saved, plus a cause vector.

Two configuration inputs change what counts as undefined. Floating-point instructions are undefined when the floating-point unit is absent or in standby. Register-bank instructions are undefined when no register bank exists.

Some classes are legal in normal code but forbidden in the slot. These are instructions that change the PC, 32-bit-long encodings, the bank restore and the divide instructions. A flush input closes any open slot and clears the stored target.

Top module: `slot_guard`

## Requirements
- R1: While reset is held, `slot_open` is 0, `slot_pc` is 0, `slot_illegal` is 0 and `slot_cause` is 0.
- R2: A valid delayed branch decoded while no slot is open and `flush` is low sets `slot_open` to 1 from the next cycle. It also loads its target into `slot_pc`. Cycles with `in_valid` low leave both unchanged.
- R3: An open slot closes after exactly one valid instruction, whatever that instruction is. A delayed branch inside the slot does not open a new slot.
- R4: A valid instruction in an open slot with `in_undef` set raises `slot_illegal` in the same cycle, with `slot_cause` bit 0 (undefined) set.
- R5: A floating-point instruction (`in_fpu_op`) in an open slot sets cause bit 0 when `cfg_fpu_present` is 0 or `cfg_fpu_standby` is 1. It is legal when the unit is present and not in standby.
- R6: A register-bank instruction (`in_bank_op`) in an open slot sets cause bit 0 when `cfg_bank_present` is 0. It is legal when the bank exists.
- R7: An instruction in an open slot that writes the PC (`in_pc_write`) or is itself a delayed branch sets cause bit 1.
- R8: A 32-bit-long instruction (`in_wide`) in an open slot sets cause bit 2.
- R9: A bank restore (`in_bank_restore`) or a signed or unsigned divide (`in_divide`) in an open slot sets cause bit 3, whatever the configuration.
- R10: While no slot is open, `slot_illegal` is 0 and `slot_cause` is 0 for every instruction class.
- R11: Whenever `slot_illegal` is 1, `slot_pc` holds the target of the delayed branch that opened the slot. `slot_illegal` is 1 exactly when `slot_cause` is nonzero.
- R12: `flush` high masks `slot_illegal` in the same cycle. From the next cycle `slot_open` is 0 and `slot_pc` is 0, and no slot is opened by a branch decoded in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush |
| in_valid | input | 1 | Decoded instruction valid |
| in_delayed_br | input | 1 | Instruction is a delayed branch |
| in_br_target | input | ADDR_W | Target of the delayed branch |
| in_undef | input | 1 | Undefined encoding |
| in_pc_write | input | 1 | Instruction modifies the PC |
| in_fpu_op | input | 1 | Floating-point or FPU-related instruction |
| in_bank_op | input | 1 | Register-bank instruction |
| in_wide | input | 1 | 32-bit-long encoding |
| in_bank_restore | input | 1 | Register-bank restore instruction |
| in_divide | input | 1 | Signed or unsigned divide instruction |
| cfg_fpu_present | input | 1 | Floating-point unit exists |
| cfg_fpu_standby | input | 1 | Floating-point unit in standby |
| cfg_bank_present | input | 1 | Register bank exists |
| slot_open | output | 1 | Current valid instruction occupies a delay slot |
| slot_pc | output | ADDR_W | Stored branch target, PC to save |
| slot_illegal | output | 1 | Slot-illegal exception request |
| slot_cause | output | 4 | Cause: bit0 undefined, bit1 PC change, bit2 wide, bit3 restricted |

## Verification
Directed cases place each class once in a slot and once outside a slot. The outside case shows that position alone decides legality. Floating-point and bank instructions are swept across all configuration settings, which separates configuration-driven undefined from slot-only restrictions.

Back-to-back delayed branches, gaps with `in_valid` low and flushes landing inside an open slot check the one-instruction window. Random streams then mix all flags, configurations and gaps. A bench model compares the cause vector and the saved target cycle by cycle.

// File: rtl/slot_guard.sv
module slot_guard #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic              in_delayed_br,
  input  logic [ADDR_W-1:0] in_br_target,
  input  logic              in_undef,
  input  logic              in_pc_write,
  input  logic              in_fpu_op,
  input  logic              in_bank_op,
  input  logic              in_wide,
  input  logic              in_bank_restore,
  input  logic              in_divide,
  input  logic              cfg_fpu_present,
  input  logic              cfg_fpu_standby,
  input  logic              cfg_bank_present,
  output logic              slot_open,
  output logic [ADDR_W-1:0] slot_pc,
  output logic              slot_illegal,
  output logic [3:0]        slot_cause
);

  logic fpu_usable;
  logic treat_undef;
  logic judged;
  logic arm;

  assign fpu_usable  = cfg_fpu_present & ~cfg_fpu_standby;
  assign treat_undef = in_undef
                     | (in_fpu_op & ~fpu_usable)
                     | (in_bank_op & ~cfg_bank_present);

  assign judged = slot_open & in_valid & ~flush;
  assign arm    = in_valid & in_delayed_br & ~slot_open & ~flush;

  assign slot_cause[0] = judged & treat_undef;
  assign slot_cause[1] = judged & (in_pc_write | in_delayed_br);
  assign slot_cause[2] = judged & in_wide;
  assign slot_cause[3] = judged & (in_bank_restore | in_divide);
  assign slot_illegal  = |slot_cause;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      slot_open <= 1'b0;
      slot_pc   <= '0;
    end else if (in_valid) begin
      slot_open <= arm;
      if (arm) slot_pc <= in_br_target;
    end
  end

endmodule

module slot_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              in_valid,
  input logic              in_delayed_br,
  input logic [ADDR_W-1:0] in_br_target,
  input logic              slot_open,
  input logic [ADDR_W-1:0] slot_pc,
  input logic              slot_illegal,
  input logic [3:0]        slot_cause
);

  AST_ARM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_delayed_br && !slot_open && !flush) |=> (slot_open && slot_pc == $past(in_br_target))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_open && !in_valid && !flush) |=> (slot_open && $stable(slot_pc))); // R2

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_open && in_valid) |=> !slot_open); // R3

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_open |-> (!slot_illegal && slot_cause == 4'd0)); // R10

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_illegal |-> (in_valid && slot_cause != 4'd0)); // R11

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!slot_open && slot_pc == '0)); // R12

  AST_FLUSH_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !slot_illegal); // R12

endmodule

bind slot_guard slot_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
  .in_delayed_br(in_delayed_br), .in_br_target(in_br_target),
  .slot_open(slot_open), .slot_pc(slot_pc),
  .slot_illegal(slot_illegal), .slot_cause(slot_cause)
);

// File: tb/sim_slot_guard.sv
module sim_slot_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n, flush, in_valid, in_delayed_br;
  logic [AW-1:0] in_br_target;
  logic in_undef, in_pc_write, in_fpu_op, in_bank_op, in_wide, in_bank_restore, in_divide;
  logic cfg_fpu_present, cfg_fpu_standby, cfg_bank_present;
  logic slot_open, slot_illegal;
  logic [AW-1:0] slot_pc;
  logic [3:0] slot_cause;

  int checks = 0;
  int errors = 0;
  logic exp_open;
  logic [AW-1:0] exp_tgt;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_guard #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_delayed_br(in_delayed_br), .in_br_target(in_br_target),
    .in_undef(in_undef), .in_pc_write(in_pc_write), .in_fpu_op(in_fpu_op),
    .in_bank_op(in_bank_op), .in_wide(in_wide), .in_bank_restore(in_bank_restore),
    .in_divide(in_divide), .cfg_fpu_present(cfg_fpu_present),
    .cfg_fpu_standby(cfg_fpu_standby), .cfg_bank_present(cfg_bank_present),
    .slot_open(slot_open), .slot_pc(slot_pc),
    .slot_illegal(slot_illegal), .slot_cause(slot_cause)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] model_cause();
    logic [3:0] c;
    logic j;
    j = exp_open && in_valid && !flush;
    c[0] = j && (in_undef || (in_fpu_op && (!cfg_fpu_present || cfg_fpu_standby))
                 || (in_bank_op && !cfg_bank_present));
    c[1] = j && (in_pc_write || in_delayed_br);
    c[2] = j && in_wide;
    c[3] = j && (in_bank_restore || in_divide);
    return c;
  endfunction

  function automatic string cause_tag(input logic [3:0] c);
    if (!exp_open) return "R10";
    if (flush) return "R12";
    if (c[0]) return in_fpu_op ? "R5" : (in_bank_op ? "R6" : "R4");
    if (c[1]) return "R7";
    if (c[2]) return "R8";
    if (c[3]) return "R9";
    if (in_fpu_op) return "R5";
    if (in_bank_op) return "R6";
    return "R3";
  endfunction

  task automatic clear_ins();
    flush = 0; in_valid = 0; in_delayed_br = 0; in_br_target = '0;
    in_undef = 0; in_pc_write = 0; in_fpu_op = 0; in_bank_op = 0;
    in_wide = 0; in_bank_restore = 0; in_divide = 0;
  endtask

  // inputs already set after a negedge; check, then advance one clock
  task automatic cycle();
    logic [3:0] ec;
    logic nopen;
    logic [AW-1:0] ntgt;
    #1;
    ec = model_cause();
    check(exp_open ? "R3" : "R2", {63'd0, slot_open}, {63'd0, exp_open});
    check((ec != 0) ? "R11" : "R2", {32'd0, slot_pc}, {32'd0, exp_tgt});
    check(cause_tag(ec), {60'd0, slot_cause}, {60'd0, ec});
    check("R11", {63'd0, slot_illegal}, {63'd0, (ec != 0)});
    if (flush) begin nopen = 0; ntgt = '0; end
    else if (in_valid) begin
      nopen = in_delayed_br && !exp_open;
      ntgt = nopen ? in_br_target : exp_tgt;
    end else begin nopen = exp_open; ntgt = exp_tgt; end
    @(posedge clk);
    exp_open = nopen; exp_tgt = ntgt;
    @(negedge clk);
    clear_ins();
  endtask

  task automatic branch(input logic [AW-1:0] t);
    in_valid = 1; in_delayed_br = 1; in_br_target = t; cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_ins();
    rst_n = 0;
    cfg_fpu_present = 1; cfg_fpu_standby = 0; cfg_bank_present = 1;
    exp_open = 0; exp_tgt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", {63'd0, slot_open}, 64'd0);
    check("R1", {32'd0, slot_pc}, 64'd0);
    check("R1", {60'd0, slot_cause, slot_illegal}, 64'd0);
    rst_n = 1;

    // R10: forbidden classes outside a slot
    in_valid = 1; in_undef = 1; in_wide = 1; in_divide = 1; in_pc_write = 1; cycle();
    // R4 undefined in slot, with idle gap held (R2)
    branch(32'h0000_1000); cycle();
    in_valid = 1; in_undef = 1; cycle();
    // R5 fpu sweep
    for (int k = 0; k < 4; k++) begin
      cfg_fpu_present = k[0]; cfg_fpu_standby = k[1];
      branch(32'h2000 + k);
      in_valid = 1; in_fpu_op = 1; cycle();
    end
    cfg_fpu_present = 1; cfg_fpu_standby = 0;
    // R6 bank sweep
    for (int k = 0; k < 2; k++) begin
      cfg_bank_present = k[0];
      branch(32'h3000 + k);
      in_valid = 1; in_bank_op = 1; cycle();
    end
    cfg_bank_present = 1;
    // R7 branch in slot does not re-arm (R3)
    branch(32'h4000); branch(32'h5000);
    in_valid = 1; in_wide = 1; cycle();
    // R8 wide, R9 restore, divide
    branch(32'h6000); in_valid = 1; in_wide = 1; cycle();
    branch(32'h7000); in_valid = 1; in_bank_restore = 1; cycle();
    branch(32'h8000); in_valid = 1; in_divide = 1; cycle();
    // R12 flush in slot masks and clears; branch with flush ignored
    branch(32'h9000); in_valid = 1; in_undef = 1; flush = 1; cycle();
    in_valid = 1; in_undef = 1; cycle();
    in_valid = 1; in_delayed_br = 1; in_br_target = 32'hA000; flush = 1; cycle();
    in_valid = 1; in_wide = 1; cycle();

    // random stream with a fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0) begin
        cfg_fpu_present = 1'($urandom); cfg_fpu_standby = 1'($urandom);
        cfg_bank_present = 1'($urandom);
      end
      in_valid = ($urandom % 4) != 0;
      in_delayed_br = ($urandom % 3) == 0;
      in_br_target = $urandom;
      in_undef = ($urandom % 8) == 0;
      in_pc_write = ($urandom % 8) == 0;
      in_fpu_op = ($urandom % 5) == 0;
      in_bank_op = ($urandom % 5) == 0;
      in_wide = ($urandom % 8) == 0;
      in_bank_restore = ($urandom % 10) == 0;
      in_divide = ($urandom % 10) == 0;
      flush = ($urandom % 20) == 0;
      cycle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule